// File: doc/BRIEF.md
# Watermark FIFO Pair

This block sits between a register bus and a serial frame shifter. It holds two first-in first-out queues of 8-bit words, each eight entries deep. The transmit queue is filled by register writes and drained by the shifter, one word per `tx_pop` strobe. The receive queue is filled by the shifter, one word per `rx_push` strobe, and drained by register reads. Register access is single cycle: read data depends on the current state and the select lines alone, and a read of the receive data register removes the word it returns at the next clock edge.

Software learns that the queues need service through two watermark conditions. Each one is derived from queue occupancy and a programmable mark, so it follows the level of the queue and clears itself once the condition no longer holds. An enable register masks each condition onto a single interrupt line. A driver typically sets the receive mark to one less than the number of words it has queued for transmit, and then waits for the receive watermark.

Top module: `wmq_fifo_pair`

## Requirements
- R1: After reset the transmit mark reads 1, the receive mark reads 0, the enable register reads 0, `irq` is low, both queues are empty, and the pending register reads 1.
- R2: A write with select 0 pushes `reg_wdata[7:0]` into the transmit queue. While the queue holds a word, `tx_avail` is high and `tx_word` shows the oldest word. `tx_pop` removes that word. Words leave in the order they were written.
- R3: A read with select 0 returns the queue-full flag in bit 31 and zeros in every other bit. A write with select 0 while eight words are held is dropped.
- R4: A read with select 1 on a non-empty receive queue returns the oldest received word in bits [7:0] with bit 31 clear, and removes that word at the clock edge. Words leave in the order they arrived.
- R5: A read with select 1 on an empty receive queue returns 32'h8000_0000 and leaves the queue unchanged.
- R6: `rx_push` stores `rx_word` when the receive queue is not full. `rx_room` is low exactly while eight words are held, and a push in that state is dropped.
- R7: A push and a pop in the same cycle on a queue that is neither empty nor full leave its occupancy unchanged.
- R8: Bit 0 of the pending register (select 5) is set exactly while transmit occupancy is below the transmit mark (select 2, bits [3:0]).
- R9: Bit 1 of the pending register is set exactly while receive occupancy is above the receive mark (select 3, bits [3:0]). With the mark at n-1, the bit rises when the n-th word arrives.
- R10: The pending register is read-only: writes to it change nothing, and its bits [31:2] read zero.
- R11: The enable register (select 4, bits [1:0], bit 0 transmit and bit 1 receive) is readable and writable. `irq` is high exactly when some pending bit and its enable bit are both set.
- R12: Selects 2, 3 and 4 read back their stored fields zero-extended. Selects 6 and 7 read zero and ignore writes. Reads with any select other than 1 have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current select |
| tx_word | output | 8 | Oldest transmit word, toward the shifter |
| tx_avail | output | 1 | Transmit queue holds at least one word |
| tx_pop | input | 1 | Shifter takes the oldest transmit word |
| rx_word | input | 8 | Received word from the shifter |
| rx_push | input | 1 | Shifter delivers `rx_word` |
| rx_room | output | 1 | Receive queue can accept a word |
| irq | output | 1 | Enabled watermark interrupt |

## Verification
Each queue has two owners, so a register access and a shifter strobe can hit the same queue in one cycle. A transmit-data write can coincide with `tx_pop`, and a receive-data read can coincide with `rx_push`. The random phase raises both sides of each queue independently every cycle. A directed run also holds a partly filled transmit queue under simultaneous write and pop, and afterwards the pending bit against a mark one above the starting depth shows that the occupancy stayed put. The bench judges every cycle against a queue model: it pops before it pushes and decides acceptance from the state at the start of the cycle, so a write to a full queue is still dropped even when the shifter pops in that same cycle.

// File: rtl/wmq_pkg.sv
package wmq_pkg;

    localparam int DATA_W  = 8;
    localparam int DEPTH   = 8;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int REG_W   = 32;
    localparam int SEL_W   = 3;
    localparam int NUM_IRQ = 2;

    localparam int IRQ_TX = 0;
    localparam int IRQ_RX = 1;

    localparam logic [CNT_W-1:0] TX_MARK_RST = CNT_W'(1);
    localparam logic [CNT_W-1:0] RX_MARK_RST = CNT_W'(0);

    typedef enum logic [SEL_W-1:0] {
        SEL_TXD = 3'd0,
        SEL_RXD = 3'd1,
        SEL_TXM = 3'd2,
        SEL_RXM = 3'd3,
        SEL_IEN = 3'd4,
        SEL_IPD = 3'd5,
        SEL_RS6 = 3'd6,
        SEL_RS7 = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0]   tx_mark;
        logic [CNT_W-1:0]   rx_mark;
        logic [NUM_IRQ-1:0] ie;
    } wm_cfg_t;

    localparam wm_cfg_t CFG_RST = '{tx_mark: TX_MARK_RST, rx_mark: RX_MARK_RST, ie: '0};

    function automatic logic [REG_W-1:0] flag_word(input logic flag,
                                                   input logic [DATA_W-1:0] data);
        logic [REG_W-1:0] w;
        w = REG_W'(data);
        w[REG_W-1] = flag;
        return w;
    endfunction

endpackage

// File: rtl/wmq_fifo.sv
module wmq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/wmq_regs.sv
module wmq_regs
    import wmq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 tx_full,
    input  logic                 rx_empty,
    input  logic [DATA_W-1:0]    rx_head,
    input  logic [NUM_IRQ-1:0]   ip,
    output logic                 tx_push,
    output logic [DATA_W-1:0]    tx_push_data,
    output logic                 rx_pop,
    output wm_cfg_t              cfg,
    output logic [REG_W-1:0]     rdata
);

    reg_sel_e sel_e;

    assign sel_e        = reg_sel_e'(sel);
    assign tx_push      = wr && (sel_e == SEL_TXD);
    assign tx_push_data = wdata[DATA_W-1:0];
    assign rx_pop       = rd && (sel_e == SEL_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RST;
        end else if (wr) begin
            case (sel_e)
                SEL_TXM: cfg.tx_mark <= wdata[CNT_W-1:0];
                SEL_RXM: cfg.rx_mark <= wdata[CNT_W-1:0];
                SEL_IEN: cfg.ie      <= wdata[NUM_IRQ-1:0];
                default: cfg         <= cfg;
            endcase
        end
    end

    always_comb begin
        case (sel_e)
            SEL_TXD: rdata = flag_word(tx_full, '0);
            SEL_RXD: rdata = flag_word(rx_empty, rx_head);
            SEL_TXM: rdata = REG_W'(cfg.tx_mark);
            SEL_RXM: rdata = REG_W'(cfg.rx_mark);
            SEL_IEN: rdata = REG_W'(cfg.ie);
            SEL_IPD: rdata = REG_W'(ip);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/wmq_irq.sv
module wmq_irq
    import wmq_pkg::*;
(
    input  logic [CNT_W-1:0]   tx_cnt,
    input  logic [CNT_W-1:0]   rx_cnt,
    input  wm_cfg_t            cfg,
    output logic [NUM_IRQ-1:0] ip,
    output logic               irq
);

    logic [NUM_IRQ-1:0] gated;

    assign ip[IRQ_TX] = (tx_cnt < cfg.tx_mark);
    assign ip[IRQ_RX] = (rx_cnt > cfg.rx_mark);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_gate
        assign gated[g] = ip[g] & cfg.ie[g];
    end

    assign irq = |gated;

endmodule

// File: rtl/wmq_fifo_pair.sv
module wmq_fifo_pair
    import wmq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_avail,
    input  logic              tx_pop,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_push,
    output logic              rx_room,
    output logic              irq
);

    logic               tx_push;
    logic [DATA_W-1:0]  tx_push_data;
    logic               tx_full;
    logic               tx_empty;
    logic [CNT_W-1:0]   tx_cnt;
    logic               rx_pop;
    logic [DATA_W-1:0]  rx_head;
    logic               rx_full;
    logic               rx_empty;
    logic [CNT_W-1:0]   rx_cnt;
    logic [NUM_IRQ-1:0] ip;
    wm_cfg_t            cfg;

    wmq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk      (clk),
        .rst      (rst),
        .push     (tx_push),
        .push_data(tx_push_data),
        .pop      (tx_pop),
        .head     (tx_word),
        .full     (tx_full),
        .empty    (tx_empty),
        .count    (tx_cnt)
    );

    wmq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk      (clk),
        .rst      (rst),
        .push     (rx_push),
        .push_data(rx_word),
        .pop      (rx_pop),
        .head     (rx_head),
        .full     (rx_full),
        .empty    (rx_empty),
        .count    (rx_cnt)
    );

    wmq_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .sel         (reg_sel),
        .wr          (reg_wr),
        .rd          (reg_rd),
        .wdata       (reg_wdata),
        .tx_full     (tx_full),
        .rx_empty    (rx_empty),
        .rx_head     (rx_head),
        .ip          (ip),
        .tx_push     (tx_push),
        .tx_push_data(tx_push_data),
        .rx_pop      (rx_pop),
        .cfg         (cfg),
        .rdata       (reg_rdata)
    );

    wmq_irq u_irq (
        .tx_cnt(tx_cnt),
        .rx_cnt(rx_cnt),
        .cfg   (cfg),
        .ip    (ip),
        .irq   (irq)
    );

    assign tx_avail = !tx_empty;
    assign rx_room  = !rx_full;

endmodule

// File: rtl/wmq_fifo_pair_chk.sv
module wmq_fifo_pair_chk
    import wmq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [SEL_W-1:0]   reg_sel,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic               tx_pop,
    input logic               rx_push,
    input logic               rx_room,
    input logic               irq,
    input logic [CNT_W-1:0]   tx_cnt,
    input logic [CNT_W-1:0]   rx_cnt,
    input logic [NUM_IRQ-1:0] ie
);

    // R3: transmit occupancy never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= CNT_W'(DEPTH));

    // R3: a data write into a full transmit queue with no pop is dropped
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt == CNT_W'(DEPTH) && reg_wr && reg_sel == 3'd0 && !tx_pop)
        |=> tx_cnt == CNT_W'(DEPTH));

    // R5: a data read of an empty receive queue with no push leaves it empty
    p_empty_read_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == '0 && reg_rd && reg_sel == 3'd1 && !rx_push)
        |=> rx_cnt == '0);

    // R6: no room is reported only while the receive queue is full
    p_room_flag_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_room |-> rx_cnt == CNT_W'(DEPTH));

    // R7: push and pop in one cycle on a partly filled queue keep occupancy
    p_keep_occ_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt != '0 && tx_cnt != CNT_W'(DEPTH) && reg_wr && reg_sel == 3'd0 && tx_pop)
        |=> $stable(tx_cnt));

    // R11: the interrupt line needs at least one enable bit
    p_irq_gated_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie != '0);

endmodule

bind wmq_fifo_pair wmq_fifo_pair_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .reg_sel(reg_sel),
    .reg_wr (reg_wr),
    .reg_rd (reg_rd),
    .tx_pop (tx_pop),
    .rx_push(rx_push),
    .rx_room(rx_room),
    .irq    (irq),
    .tx_cnt (tx_cnt),
    .rx_cnt (rx_cnt),
    .ie     (cfg.ie)
);

// File: tb/wmq_fifo_pair_test.sv
module wmq_fifo_pair_test;

    localparam int QD   = 8;
    localparam int MW   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_word;
    logic        tx_avail;
    logic        tx_pop = 1'b0;
    logic [7:0]  rx_word = '0;
    logic        rx_push = 1'b0;
    logic        rx_room;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [3:0] m_txm = 4'd1;
    logic [3:0] m_rxm = 4'd0;
    logic [1:0] m_ie  = 2'd0;

    wmq_fifo_pair uut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_word(tx_word),
        .tx_avail(tx_avail), .tx_pop(tx_pop), .rx_word(rx_word), .rx_push(rx_push),
        .rx_room(rx_room), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_ip();
        return {(rxq.size() > int'(m_rxm)), (txq.size() < int'(m_txm))};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [2:0] s);
        case (s)
            3'd0: return {(txq.size() == QD), 31'b0};
            3'd1: return (rxq.size() == 0) ? 32'h8000_0000 : {24'b0, rxq[0]};
            3'd2: return {28'b0, m_txm};
            3'd3: return {28'b0, m_rxm};
            3'd4: return {30'b0, m_ie};
            3'd5: return {30'b0, exp_ip()};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string sel_tag(input logic [2:0] s);
        case (s)
            3'd0: return "R3 txdata";
            3'd1: return "R4 rxdata";
            3'd4: return "R11 enable";
            3'd5: return "R8 pending";
            default: return "R12 readback";
        endcase
    endfunction

    // One bus cycle: drive at negedge, check combinational outputs, then update the model
    task automatic cyc(input logic [2:0] s, input logic w, input logic r, input logic [31:0] wd,
                       input logic tp, input logic rp, input logic [7:0] rw, input string ov);
        bit tx_full_pre, tx_empty_pre, rx_full_pre, rx_empty_pre;
        @(negedge clk);
        reg_sel = s; reg_wr = w; reg_rd = r; reg_wdata = wd;
        tx_pop = tp; rx_push = rp; rx_word = rw;
        #1;
        chk((ov != "") ? ov : sel_tag(s), reg_rdata, exp_rd(s));
        chk("R2 tx_avail", {31'b0, tx_avail}, {31'b0, txq.size() != 0});
        if (txq.size() != 0) chk("R2 tx_word order", {24'b0, tx_word}, {24'b0, txq[0]});
        chk("R6 rx_room", {31'b0, rx_room}, {31'b0, rxq.size() != QD});
        chk("R11 irq", {31'b0, irq}, {31'b0, |(exp_ip() & m_ie)});
        @(posedge clk);
        tx_full_pre  = (txq.size() == QD);
        tx_empty_pre = (txq.size() == 0);
        rx_full_pre  = (rxq.size() == QD);
        rx_empty_pre = (rxq.size() == 0);
        if (tp && !tx_empty_pre) void'(txq.pop_front());
        if (w && s == 3'd0 && !tx_full_pre) txq.push_back(wd[7:0]);
        if (r && s == 3'd1 && !rx_empty_pre) void'(rxq.pop_front());
        if (rp && !rx_full_pre) rxq.push_back(rw);
        if (w && s == 3'd2) m_txm = wd[MW-1:0];
        if (w && s == 3'd3) m_rxm = wd[MW-1:0];
        if (w && s == 3'd4) m_ie  = wd[1:0];
    endtask

    task automatic idle(input logic [2:0] s, input string ov);
        cyc(s, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 8'h0, ov);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset defaults
        for (int s = 0; s < 6; s++) idle(3'(s), "R1 reset");

        // R2, R3: fill beyond capacity, the ninth write is dropped
        for (int i = 0; i < 9; i++) cyc(3'd0, 1'b1, 1'b0, 32'hA0 + i, 1'b0, 1'b0, 8'h0, "");
        idle(3'd0, "R3 full flag");
        for (int i = 0; i < 8; i++) cyc(3'd5, 1'b0, 1'b0, 0, 1'b1, 1'b0, 8'h0, "R2 drain");
        idle(3'd0, "R2 drained");

        // R5: empty reads change nothing, a following word is read intact
        cyc(3'd1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 8'h0, "R5 empty read");
        cyc(3'd1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 8'h0, "R5 empty read");
        cyc(3'd1, 1'b0, 1'b0, 0, 1'b0, 1'b1, 8'h5A, "R5 empty");
        cyc(3'd1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 8'h0, "R5 word after empty reads");

        // R6, R4: overfill the receive queue and read it back in order
        for (int i = 0; i < 9; i++) cyc(3'd7, 1'b0, 1'b0, 0, 1'b0, 1'b1, 8'h30 + 8'(i), "R12 reserved");
        for (int i = 0; i < 9; i++) cyc(3'd1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 8'h0, "R4 ordered read");

        // R9: mark n-1 = 2 signals at the third word
        cyc(3'd3, 1'b1, 1'b0, 32'h2, 1'b0, 1'b0, 8'h0, "");
        for (int i = 0; i < 3; i++) cyc(3'd5, 1'b0, 1'b0, 0, 1'b0, 1'b1, 8'h70 + 8'(i), "R9 rx mark");
        idle(3'd5, "R9 rx mark reached");

        // R10: pending register ignores writes
        cyc(3'd5, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'h0, "R10 pending write");
        cyc(3'd5, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 8'h0, "R10 pending write");
        idle(3'd5, "R10 pending unchanged");

        // R11: enables gate the pending bits onto irq
        cyc(3'd4, 1'b1, 1'b0, 32'h2, 1'b0, 1'b0, 8'h0, "");
        idle(3'd4, "R11 enable rx");
        cyc(3'd4, 1'b1, 1'b0, 32'h1, 1'b0, 1'b0, 8'h0, "");
        idle(3'd4, "R11 enable tx");

        // R7: simultaneous push and pop on a partly filled transmit queue
        cyc(3'd2, 1'b1, 1'b0, 32'h5, 1'b0, 1'b0, 8'h0, "");
        for (int i = 0; i < 4; i++) cyc(3'd0, 1'b1, 1'b0, 32'hC0 + i, 1'b0, 1'b0, 8'h0, "");
        for (int i = 0; i < 6; i++) cyc(3'd0, 1'b1, 1'b0, 32'hD0 + i, 1'b1, 1'b0, 8'h0, "R7 push+pop");
        idle(3'd5, "R7 occupancy kept");

        // Random phase: both owners of each queue act independently
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] s;
            logic [31:0] wd;
            s  = 3'($urandom % 8);
            wd = $urandom;
            if (s == 3'd2 || s == 3'd3) wd = wd & 32'hF;
            cyc(s, ($urandom % 3) == 0, ($urandom % 3) == 0, wd,
                ($urandom % 3) == 0, ($urandom % 3) == 0, 8'($urandom), "");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule